// File: doc/BRIEF.md
# Indirectly Addressed Vectored Interrupt Controller

This block collects up to 128 interrupt request lines and presents a single active-low interrupt line to a processor. Software never sees one register bank per source. It writes a source index into a select register. A shared mode register, a shared vector register and four write-only command registers then reach the state of that one source: enable, disable, clear pending and set pending. Each source carries a 3-bit priority, a 2-bit trigger type, a vector word, an enable bit and a pending bit.

To service an interrupt, software reads the take register. The read returns the vector of the best eligible source and pushes that source onto a nesting stack. A source is eligible when it is enabled, pending and of higher priority than the stack top. When no source is eligible, the read returns the programmed spurious vector and changes nothing. A status register reports which source is being serviced. A write to the end-of-service register pops one nesting level. Priorities rise strictly from level to level, so the stack never holds more than eight entries, and eight end-of-service writes always leave the controller idle.

Top module: `indirect_irq_ctrl`

## Requirements
- R1: After reset all sources are disabled and not pending, the stack is empty, the select register (0x00) reads 0, the status register (0x18) reads 0, the spurious vector (0x3C) reads 0 and irq_n is high.
- R2: The select register at 0x00 holds a source index in bits [6:0]. The mode register at 0x04 (priority in bits [2:0], trigger type in bits [6:5]) and the vector register at 0x08 read and write only the selected source. When the index is not below NUM_SRC, writes to them are ignored and reads return 0.
- R3: Command writes act on the selected source only: 0x40 enables it, 0x44 disables it, 0x48 clears its pending bit and 0x4C sets it. Bit 0 of the read-only register at 0x30 reports the enable bit of the selected source.
- R4: A read of 0x10 returns the vector of the winning eligible source and pushes it onto the stack. With no eligible source it returns the spurious vector from 0x3C and leaves the stack alone. Read data is valid in the cycle after the read strobe.
- R5: Arbitration picks the enabled pending source of highest priority (0 lowest, 7 highest) and breaks ties toward the lowest index. The winner must be strictly above the stack-top priority; when the stack is empty any priority qualifies.
- R6: Trigger type 00 is level-high, 01 rising edge, 10 level-low and 11 falling edge. An edge latches the pending bit, and the take read that selects the source clears it. A level source stays pending while its input is active.
- R7: irq_n is low exactly when some enabled pending source has a priority above the current stack level. It follows an input or register change one clock edge later.
- R8: The status register at 0x18 returns the index of the source at the stack top, or 0 when the stack is empty.
- R9: Any write to 0x38 pops one nesting level. On an empty stack it has no effect. Eight levels can be nested, and eight such writes always empty the stack.
- R10: A disabled source keeps its pending state but does not drive irq_n. Enabling it later raises irq_n if it is still pending and above the current level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, registered |
| src_in | input | NUM_SRC | Interrupt request lines, synchronous to clk |
| irq_n | output | 1 | Active-low interrupt request to the processor |

## Verification
Register read data appears on rdata one clock edge after the read strobe is sampled. A take read also pushes the stack and clears the edge-pending bit at that same edge, so status and irq_n show the new level immediately afterwards. Request inputs are registered once, so irq_n reacts one edge after an input change, and a command write acts at the edge that samples it. The bench drives every input at a falling edge and samples every output at the next falling edge or later, so each check lands at least half a cycle after the edge that makes its result due.

// File: rtl/irqc_pkg.sv
// Package: shared constants and types for the indirect interrupt controller.
// Assumes an 8-bit byte-offset register space and a 3-bit priority field.
package irqc_pkg;

    localparam int ADDR_W   = 8;
    localparam int SEL_W    = 7;
    localparam int PRIO_W   = 3;
    localparam int TYPE_LSB = 5;

    // Trigger-type encoding stored in mode bits [6:5]
    typedef enum logic [1:0] {
        TRG_LVL_HI = 2'b00,
        TRG_RISE   = 2'b01,
        TRG_LVL_LO = 2'b10,
        TRG_FALL   = 2'b11
    } trig_e;

    // Register offsets
    localparam logic [ADDR_W-1:0] OFS_SEL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_MODE = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_VEC  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_TAKE = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CUR  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_ENST = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_DONE = 8'h38;
    localparam logic [ADDR_W-1:0] OFS_SPUR = 8'h3C;
    localparam logic [ADDR_W-1:0] OFS_ON   = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_OFF  = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_CLR  = 8'h48;
    localparam logic [ADDR_W-1:0] OFS_SET  = 8'h4C;

endpackage

// File: rtl/irqc_src_bank.sv
// Module: per-source state for every interrupt line.
// Holds the enable, pending, priority, trigger type and vector of each source,
// samples the request lines once and produces the eligible-candidate vector.
// Assumes src_in is synchronous to clk and that sel_id is only acted on when
// sel_ok is high.
module irqc_src_bank
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32,
    parameter int ID_W    = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_SRC-1:0]               src_in,
    input  logic                             sel_ok,
    input  logic [ID_W-1:0]                  sel_id,
    input  logic                             mode_we,
    input  logic                             vec_we,
    input  logic                             en_cmd,
    input  logic                             dis_cmd,
    input  logic                             clr_cmd,
    input  logic                             set_cmd,
    input  logic [DATA_W-1:0]                wdata,
    input  logic                             take_go,
    input  logic [ID_W-1:0]                  take_id,
    output logic [NUM_SRC-1:0]               cand,
    output logic [NUM_SRC-1:0]               en_all,
    output logic [NUM_SRC-1:0][PRIO_W-1:0]   prio_all,
    output logic [NUM_SRC-1:0][1:0]          typ_all,
    output logic [NUM_SRC-1:0][DATA_W-1:0]   vec_all
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic              en_q;
        logic              pend_q;
        logic              in_q;
        logic [PRIO_W-1:0] prio_q;
        trig_e             typ_q;
        logic [DATA_W-1:0] vec_q;
        logic              mine;
        logic              taken;
        logic              edge_hit;
        logic              lvl_act;

        assign mine  = sel_ok && (sel_id == ID_W'(g));
        assign taken = take_go && (take_id == ID_W'(g));

        // Decode edge events and level activity from the sampled line
        always_comb begin
            edge_hit = 1'b0;
            lvl_act  = 1'b0;
            case (typ_q)
                TRG_LVL_HI: lvl_act  = in_q;
                TRG_LVL_LO: lvl_act  = ~in_q;
                TRG_RISE:   edge_hit = src_in[g] & ~in_q;
                TRG_FALL:   edge_hit = ~src_in[g] & in_q;
                default:    lvl_act  = 1'b0;
            endcase
        end

        // Configuration written through the shared mode/vector/command registers
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio_q <= '0;
                typ_q  <= TRG_LVL_HI;
                vec_q  <= '0;
                en_q   <= 1'b0;
            end else begin
                if (mine && mode_we) begin
                    prio_q <= wdata[PRIO_W-1:0];
                    typ_q  <= trig_e'(wdata[TYPE_LSB+1:TYPE_LSB]);
                end
                if (mine && vec_we) begin
                    vec_q <= wdata;
                end
                if (mine && en_cmd) begin
                    en_q <= 1'b1;
                end else if (mine && dis_cmd) begin
                    en_q <= 1'b0;
                end
            end
        end

        // Input sampling and the latched pending bit; a new edge wins over a clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                in_q   <= 1'b0;
                pend_q <= 1'b0;
            end else begin
                in_q   <= src_in[g];
                pend_q <= (pend_q & ~((mine && clr_cmd) || taken))
                        | (mine && set_cmd) | edge_hit;
            end
        end

        assign cand[g]     = en_q & (pend_q | lvl_act);
        assign en_all[g]   = en_q;
        assign prio_all[g] = prio_q;
        assign typ_all[g]  = typ_q;
        assign vec_all[g]  = vec_q;
    end

endmodule

// File: rtl/irqc_arbiter.sv
// Module: priority selection among eligible sources.
// Finds the highest priority among candidate sources; ties go to the lowest
// index. Purely combinational; the caller compares the result to the stack.
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ID_W    = 5
) (
    input  logic [NUM_SRC-1:0]             cand,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_all,
    output logic                           found,
    output logic [ID_W-1:0]                best_id,
    output logic [PRIO_W-1:0]              best_prio
);

    // Scan from the top index down so an equal priority moves the pick lower
    always_comb begin
        found     = 1'b0;
        best_id   = '0;
        best_prio = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (cand[i] && (!found || prio_all[i] >= best_prio)) begin
                found     = 1'b1;
                best_id   = ID_W'(i);
                best_prio = prio_all[i];
            end
        end
    end

endmodule

// File: rtl/irqc_level_stack.sv
// Module: nesting stack of serviced sources.
// Each entry holds the priority and index of a source under service. Assumes
// push and pop never arrive in the same cycle and that pushes only carry a
// priority above the current top, so DEPTH >= 2**PRIO_W never overflows.
module irqc_level_stack
    import irqc_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int ID_W  = 5,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic [ID_W-1:0]   push_id,
    output logic              empty,
    output logic              full,
    output logic [CNT_W-1:0]  depth,
    output logic [PRIO_W-1:0] top_prio,
    output logic [ID_W-1:0]   top_id
);

    logic [PRIO_W-1:0] stk_prio [DEPTH];
    logic [ID_W-1:0]   stk_id   [DEPTH];
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  top_idx;
    logic [IDX_W-1:0]  wr_idx;

    assign top_idx = IDX_W'(cnt_q - 1'b1);
    assign wr_idx  = IDX_W'(cnt_q);

    // Push writes above the top; pop only lowers the count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                stk_prio[i] <= '0;
                stk_id[i]   <= '0;
            end
        end else if (push && !full) begin
            stk_prio[wr_idx] <= push_prio;
            stk_id[wr_idx]   <= push_id;
            cnt_q            <= cnt_q + 1'b1;
        end else if (pop && !empty) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign empty    = (cnt_q == '0);
    assign full     = (cnt_q == CNT_W'(DEPTH));
    assign depth    = cnt_q;
    assign top_prio = empty ? '0 : stk_prio[top_idx];
    assign top_id   = empty ? '0 : stk_id[top_idx];

endmodule

// File: rtl/indirect_irq_ctrl.sv
// Module: top of the indirectly addressed vectored interrupt controller.
// Decodes the register space, holds the select and spurious registers, ties
// the source bank, arbiter and nesting stack together and drives irq_n.
// Assumes wr_en and rd_en are never high in the same cycle.
module indirect_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_SRC   = 32,
    parameter int DATA_W    = 32,
    parameter int STK_DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [7:0]         addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic [NUM_SRC-1:0] src_in,
    output logic               irq_n
);

    localparam int ID_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int CNT_W = $clog2(STK_DEPTH + 1);

    logic [SEL_W-1:0]  sel_q;
    logic [DATA_W-1:0] spur_q;
    logic              sel_ok;
    logic [ID_W-1:0]   sel_id;

    logic [NUM_SRC-1:0]              cand;
    logic [NUM_SRC-1:0]              en_all;
    logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_all;
    logic [NUM_SRC-1:0][1:0]         typ_all;
    logic [NUM_SRC-1:0][DATA_W-1:0]  vec_all;

    logic              found;
    logic [ID_W-1:0]   best_id;
    logic [PRIO_W-1:0] best_prio;

    logic              stk_empty;
    logic              stk_full;
    logic [CNT_W-1:0]  stk_depth;
    logic [PRIO_W-1:0] top_prio;
    logic [ID_W-1:0]   top_id;

    logic              win_ok;
    logic              take_rd;
    logic              take_go;
    logic              done_wr;
    logic [DATA_W-1:0] rd_mux;

    assign sel_ok  = (32'(sel_q) < NUM_SRC);
    assign sel_id  = ID_W'(sel_q);
    assign win_ok  = found && (stk_empty || best_prio > top_prio);
    assign take_rd = rd_en && (addr == OFS_TAKE);
    assign take_go = take_rd && win_ok;
    assign done_wr = wr_en && (addr == OFS_DONE);

    // Select and spurious-vector registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            spur_q <= '0;
        end else if (wr_en) begin
            if (addr == OFS_SEL)  sel_q  <= wdata[SEL_W-1:0];
            if (addr == OFS_SPUR) spur_q <= wdata;
        end
    end

    irqc_src_bank #(
        .NUM_SRC (NUM_SRC),
        .DATA_W  (DATA_W),
        .ID_W    (ID_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_in   (src_in),
        .sel_ok   (sel_ok),
        .sel_id   (sel_id),
        .mode_we  (wr_en && addr == OFS_MODE),
        .vec_we   (wr_en && addr == OFS_VEC),
        .en_cmd   (wr_en && addr == OFS_ON),
        .dis_cmd  (wr_en && addr == OFS_OFF),
        .clr_cmd  (wr_en && addr == OFS_CLR),
        .set_cmd  (wr_en && addr == OFS_SET),
        .wdata    (wdata),
        .take_go  (take_go),
        .take_id  (best_id),
        .cand     (cand),
        .en_all   (en_all),
        .prio_all (prio_all),
        .typ_all  (typ_all),
        .vec_all  (vec_all)
    );

    irqc_arbiter #(
        .NUM_SRC (NUM_SRC),
        .ID_W    (ID_W)
    ) u_arb (
        .cand      (cand),
        .prio_all  (prio_all),
        .found     (found),
        .best_id   (best_id),
        .best_prio (best_prio)
    );

    irqc_level_stack #(
        .DEPTH (STK_DEPTH),
        .ID_W  (ID_W)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (take_go),
        .pop       (done_wr),
        .push_prio (best_prio),
        .push_id   (best_id),
        .empty     (stk_empty),
        .full      (stk_full),
        .depth     (stk_depth),
        .top_prio  (top_prio),
        .top_id    (top_id)
    );

    // Read-data selection by offset
    always_comb begin
        rd_mux = '0;
        case (addr)
            OFS_SEL:  rd_mux = DATA_W'(sel_q);
            OFS_MODE: if (sel_ok) begin
                          rd_mux[PRIO_W-1:0]            = prio_all[sel_id];
                          rd_mux[TYPE_LSB+1:TYPE_LSB]   = typ_all[sel_id];
                      end
            OFS_VEC:  if (sel_ok) rd_mux = vec_all[sel_id];
            OFS_TAKE: rd_mux = win_ok ? vec_all[best_id] : spur_q;
            OFS_CUR:  rd_mux = DATA_W'(top_id);
            OFS_ENST: if (sel_ok) rd_mux[0] = en_all[sel_id];
            OFS_SPUR: rd_mux = spur_q;
            default:  rd_mux = '0;
        endcase
    end

    // Registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end

    assign irq_n = ~win_ok;

endmodule

// File: rtl/indirect_irq_ctrl_chk.sv
// Module: assertion checker bound to the controller top.
// Watches the register strobes, read data, stack depth and irq_n.
module indirect_irq_ctrl_chk
    import irqc_pkg::*;
#(
    parameter int NUM_SRC   = 32,
    parameter int DATA_W    = 32,
    parameter int STK_DEPTH = 8,
    localparam int ID_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int CNT_W = $clog2(STK_DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic               rd_en,
    input logic [7:0]         addr,
    input logic [DATA_W-1:0]  rdata,
    input logic               irq_n,
    input logic [DATA_W-1:0]  spur_q,
    input logic [CNT_W-1:0]   stk_depth,
    input logic               stk_full,
    input logic               take_go,
    input logic [NUM_SRC-1:0] en_all,
    input logic               sel_ok,
    input logic [ID_W-1:0]    sel_id
);

    // R9: a push never meets a full stack
    p_push_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take_go |-> !stk_full);

    // R9: an end-of-service write on a non-empty stack removes one level
    p_done_pops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_DONE && stk_depth != '0)
        |=> stk_depth == CNT_W'($past(stk_depth) - 1'b1));

    // R4: a take read while irq_n is low adds one level
    p_take_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFS_TAKE && !irq_n)
        |=> stk_depth == CNT_W'($past(stk_depth) + 1'b1));

    // R4: a take read with nothing eligible returns the spurious vector
    p_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFS_TAKE && irq_n)
        |=> (rdata == $past(spur_q)) && (stk_depth == $past(stk_depth)));

    // R3: the enable command sets the selected source's enable bit
    p_enable_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_ON && sel_ok) |=> en_all[$past(sel_id)]);

    // R7: with every source disabled and nothing in service, irq_n stays high
    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_all == '0) |-> irq_n);

endmodule

bind indirect_irq_ctrl indirect_irq_ctrl_chk #(
    .NUM_SRC   (NUM_SRC),
    .DATA_W    (DATA_W),
    .STK_DEPTH (STK_DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .rdata     (rdata),
    .irq_n     (irq_n),
    .spur_q    (spur_q),
    .stk_depth (stk_depth),
    .stk_full  (stk_full),
    .take_go   (take_go),
    .en_all    (en_all),
    .sel_ok    (sel_ok),
    .sel_id    (sel_id)
);

// File: tb/indirect_irq_ctrl_test.sv
// Directed bench: one task per scenario, each checking its own results.
module indirect_irq_ctrl_test;

    localparam int NSRC = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic            rd_en = 1'b0;
    logic [7:0]      addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [NSRC-1:0] src_in = '0;
    logic            irq_n;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    indirect_irq_ctrl #(.NUM_SRC(NSRC), .DATA_W(32), .STK_DEPTH(8)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .src_in(src_in), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Program one source: priority, trigger type, vector, optional enable
    task automatic setup_src(input int id, input int prio, input int typ,
                             input logic [31:0] vec, input bit enable);
        wr(8'h00, 32'(id));
        wr(8'h04, 32'(prio) | (32'(typ) << 5));
        wr(8'h08, vec);
        if (enable) wr(8'h40, 32'd1);
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1 irq_n idle", 32'(irq_n), 32'd1);
        rd(8'h00, d); check("R1 select", d, 32'd0);
        rd(8'h18, d); check("R1 status", d, 32'd0);
        rd(8'h3C, d); check("R1 spurious", d, 32'd0);
        rd(8'h30, d); check("R1 enable", d, 32'd0);
        rd(8'h10, d); check("R1 take gives spurious", d, 32'd0);
        rd(8'h18, d); check("R1 no push", d, 32'd0);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        wr(8'h3C, 32'hDEAD_BEEF);
        rd(8'h3C, d); check("R2 spurious readback", d, 32'hDEAD_BEEF);
        setup_src(5, 3, 1, 32'h1005, 1'b0);
        rd(8'h04, d); check("R2 mode readback", d, 32'h23);
        rd(8'h08, d); check("R2 vector readback", d, 32'h1005);
        wr(8'h00, 32'd2); wr(8'h08, 32'h1002);
        wr(8'h00, 32'd5);
        rd(8'h08, d); check("R2 other source untouched", d, 32'h1005);
        wr(8'h04, 32'h03);
        wr(8'h00, 32'd100); wr(8'h08, 32'h77);
        rd(8'h08, d); check("R2 out-of-range vector", d, 32'd0);
        rd(8'h00, d); check("R2 select bits", d, 32'd100);
    endtask

    task automatic t_cmds;
        logic [31:0] d;
        wr(8'h00, 32'd5); wr(8'h40, 32'd1);
        rd(8'h30, d); check("R3 enable selected", d, 32'd1);
        wr(8'h00, 32'd6);
        rd(8'h30, d); check("R3 neighbour stays off", d, 32'd0);
        wr(8'h00, 32'd5); wr(8'h44, 32'd1);
        rd(8'h30, d); check("R3 disable", d, 32'd0);
        wr(8'h40, 32'd1);
    endtask

    task automatic t_level_high;
        logic [31:0] d;
        src_in[5] = 1'b1;
        idle(2);
        check("R7 level raises irq", 32'(irq_n), 32'd0);
        rd(8'h10, d); check("R4 take vector", d, 32'h1005);
        rd(8'h18, d); check("R8 status source", d, 32'd5);
        check("R5 same priority not above", 32'(irq_n), 32'd1);
        wr(8'h38, 32'd0);
        rd(8'h18, d); check("R9 pop to idle", d, 32'd0);
        check("R6 level still pending", 32'(irq_n), 32'd0);
        @(negedge clk); src_in[5] = 1'b0;
        idle(2);
        check("R6 level released", 32'(irq_n), 32'd1);
    endtask

    task automatic t_edges;
        logic [31:0] d;
        setup_src(2, 2, 1, 32'h1002, 1'b1);
        setup_src(9, 2, 1, 32'h1009, 1'b1);
        src_in[7] = 1'b1;
        setup_src(7, 6, 3, 32'h1007, 1'b1);
        idle(2);
        check("R6 no fall yet", 32'(irq_n), 32'd1);
        @(negedge clk); src_in[2] = 1'b1; src_in[9] = 1'b1;
        @(negedge clk); src_in[2] = 1'b0; src_in[9] = 1'b0;
        idle(1);
        check("R6 rising latched", 32'(irq_n), 32'd0);
        rd(8'h10, d); check("R5 tie to lowest index", d, 32'h1002);
        @(negedge clk); src_in[7] = 1'b0;
        idle(2);
        check("R7 higher level preempts", 32'(irq_n), 32'd0);
        rd(8'h10, d); check("R6 falling edge vector", d, 32'h1007);
        rd(8'h18, d); check("R8 nested status", d, 32'd7);
        rd(8'h10, d); check("R5 below level gives spurious", d, 32'hDEAD_BEEF);
        wr(8'h38, 32'd0);
        rd(8'h18, d); check("R9 pop one level", d, 32'd2);
        check("R5 equal priority blocked", 32'(irq_n), 32'd1);
        wr(8'h38, 32'd0);
        check("R7 irq after full pop", 32'(irq_n), 32'd0);
        rd(8'h10, d); check("R6 second edge source", d, 32'h1009);
        wr(8'h38, 32'd0);
        rd(8'h10, d); check("R6 edge cleared by take", d, 32'hDEAD_BEEF);
    endtask

    task automatic t_soft;
        logic [31:0] d;
        setup_src(3, 1, 0, 32'h1003, 1'b0);
        wr(8'h4C, 32'd1);
        idle(1);
        check("R10 disabled holds quiet", 32'(irq_n), 32'd1);
        wr(8'h40, 32'd1);
        check("R10 enable raises", 32'(irq_n), 32'd0);
        wr(8'h48, 32'd1);
        check("R3 clear pending", 32'(irq_n), 32'd1);
        rd(8'h10, d); check("R3 cleared source not taken", d, 32'hDEAD_BEEF);
        wr(8'h4C, 32'd1);
        rd(8'h10, d); check("R3 software set taken", d, 32'h1003);
        wr(8'h38, 32'd0);
        check("R6 soft pending cleared by take", 32'(irq_n), 32'd1);
    endtask

    task automatic t_level_low;
        logic [31:0] d;
        src_in[4] = 1'b1;
        setup_src(4, 5, 2, 32'h1004, 1'b1);
        idle(1);
        check("R6 level-low inactive", 32'(irq_n), 32'd1);
        @(negedge clk); src_in[4] = 1'b0;
        idle(2);
        check("R6 level-low active", 32'(irq_n), 32'd0);
        rd(8'h10, d); check("R6 level-low vector", d, 32'h1004);
        @(negedge clk); src_in[4] = 1'b1;
        wr(8'h38, 32'd0);
        idle(1);
        check("R6 level-low released", 32'(irq_n), 32'd1);
    endtask

    task automatic t_nest;
        logic [31:0] d;
        for (int i = 0; i < 8; i++) begin
            setup_src(10 + i, i, 1, 32'h2000 + 32'(i), 1'b1);
        end
        for (int i = 0; i < 8; i++) begin
            wr(8'h00, 32'(10 + i));
            wr(8'h4C, 32'd1);
            rd(8'h10, d); check("R9 nest push", d, 32'h2000 + 32'(i));
        end
        rd(8'h18, d); check("R8 deepest level", d, 32'd17);
        for (int i = 0; i < 7; i++) wr(8'h38, 32'd0);
        rd(8'h18, d); check("R9 one level left", d, 32'd10);
        wr(8'h38, 32'd0);
        rd(8'h18, d); check("R9 eight pops empty", d, 32'd0);
        wr(8'h38, 32'd0);
        rd(8'h18, d); check("R9 pop on empty", d, 32'd0);
        check("R9 idle after pops", 32'(irq_n), 32'd1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_cmds();
        t_level_high();
        t_edges();
        t_soft();
        t_level_low();
        t_nest();
        report();
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

endmodule